// File: doc/BRIEF.md
# Smart Card Deactivation Sequencer

This block powers down a contact smart card in a fixed order once a card session ends. A session closes when host software drops its start/stop control level. It also closes at once when any of five hardware conditions appears during the session: over-current, over-temperature, a logic-supply fault, a card-supply fault, or removal of the card. The block owns four registered card controls: the card reset level, the card clock gate, the I/O reception enable and the card supply enable. It releases them in this order: reset, clock, I/O, supply. Each step waits its own delay, counted from the end of the step before it. The delays are 0.5 µs, 7.5 µs, 0.5 µs and 0.5 µs, derived from the system clock through a cycles-per-microsecond parameter.

The block opens a session in a simple way, because the real activation ordering lives elsewhere. From the off state, a rising start/stop level raises all four controls together, provided no fault is present and a card is inserted. A six-bit cause mask records every condition that was true in the cycle that ended the session. A one-cycle done pulse marks the cycle in which the supply goes off.

Top module: `card_deact_seq`

## Requirements
- R1: A synchronous reset drives all four card controls low, the done pulse low and the cause mask to zero, and leaves the block in the off state.
- R2: In the off state, if start/stop is high in a cycle after it was low, no hardware fault is present and the card is present, all four card controls are high from the next cycle on.
- R3: While a session is open, a low start/stop level ends it, and bit 0 of the cause mask is set.
- R4: While a session is open, any of the following ends it and sets its own cause bit: over-current (bit 1), over-temperature (bit 2), logic-supply fault (bit 3), card-supply fault (bit 4), card absent (bit 5). Every condition present in the ending cycle is recorded together.
- R5: With H = CYC_PER_US/2 system cycles, the card reset falls H cycles after the clock edge that sampled the ending condition.
- R6: The card clock gate falls 15·H cycles after the reset falls.
- R7: The I/O reception enable falls H cycles after the clock gate falls.
- R8: The supply enable falls H cycles after the I/O enable falls. The done output is high for exactly the first cycle in which the supply is off.
- R9: A control never falls while a control that comes earlier in the order is still high.
- R10: Once a shutdown has started, further ending conditions change neither its timing nor the cause mask.
- R11: A start/stop rising edge is refused while a shutdown runs, including on the edge at which the supply turns off. A start/stop level that stays high afterwards does not reopen a session.
- R12: In the off state, fault inputs and card removal have no effect on the outputs. An activation attempt is refused while any fault is present or the card is absent.
- R13: The cause mask keeps its value after the shutdown ends and returns to zero when the next session opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_stop | input | 1 | Software session level: a rising edge opens a session, a low level closes it |
| flt_overcurrent | input | 1 | Card over-current fault |
| flt_overtemp | input | 1 | Over-temperature fault |
| flt_logic_supply | input | 1 | Logic-supply fault |
| flt_card_supply | input | 1 | Card-supply fault |
| card_present | input | 1 | High while a card is inserted |
| card_rst_o | output | 1 | Card reset level, high while the card is out of reset |
| card_clk_en_o | output | 1 | Card clock gate |
| card_io_en_o | output | 1 | I/O reception enable |
| card_vcc_en_o | output | 1 | Card supply enable |
| deact_done_o | output | 1 | One-cycle pulse in the first cycle with the supply off |
| deact_cause_o | output | 6 | Mask of the conditions that ended the last session |

## Verification
Two functions can fall in the same cycle.

The first pair is a software close and a hardware fault. The bench clears start/stop and raises over-current in the same cycle, and expects both cause bits with unchanged step timing.

The second pair is the end of a shutdown and a new activation request. The bench raises start/stop exactly at the clock edge that switches the supply off. It expects the request to be refused, with no session reopening while the level is held, and a session to open only after a fresh low-to-high transition.

A behavioural model in the bench tracks elapsed cycles since the ending edge and judges all outputs on every cycle.

// File: rtl/card_deact_pkg.sv
package card_deact_pkg;

    // Number of recorded shutdown causes and their bit positions
    localparam int CAUSE_W    = 6;
    localparam int CZ_SW      = 0;
    localparam int CZ_OCP     = 1;
    localparam int CZ_OTP     = 2;
    localparam int CZ_LOGIC   = 3;
    localparam int CZ_CARDSUP = 4;
    localparam int CZ_REMOVAL = 5;

    // Sequencer phases: each W_* state waits for one step's interval
    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_ON    = 3'd1,
        ST_W_RST = 3'd2,
        ST_W_CLK = 3'd3,
        ST_W_IO  = 3'd4,
        ST_W_VCC = 3'd5
    } seq_state_e;

    typedef struct packed {
        seq_state_e           state;
        logic                 rst_hi;
        logic                 clk_en;
        logic                 io_en;
        logic                 vcc_en;
        logic                 done;
        logic [CAUSE_W-1:0]   cause;
        logic                 ss_prev;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RESET = '{
        state:   ST_OFF,
        rst_hi:  1'b0,
        clk_en:  1'b0,
        io_en:   1'b0,
        vcc_en:  1'b0,
        done:    1'b0,
        cause:   '0,
        ss_prev: 1'b0
    };

endpackage

// File: rtl/card_deact_trigger.sv
module card_deact_trigger
    import card_deact_pkg::*;
(
    input  logic               session_active,
    input  logic               start_stop,
    input  logic               flt_overcurrent,
    input  logic               flt_overtemp,
    input  logic               flt_logic_supply,
    input  logic               flt_card_supply,
    input  logic               card_present,
    output logic [CAUSE_W-1:0] cause_vec,
    output logic               fire,
    output logic               hw_block
);

    logic [CAUSE_W-1:0] raw_d;

    always_comb begin
        raw_d             = '0;
        raw_d[CZ_SW]      = ~start_stop;
        raw_d[CZ_OCP]     = flt_overcurrent;
        raw_d[CZ_OTP]     = flt_overtemp;
        raw_d[CZ_LOGIC]   = flt_logic_supply;
        raw_d[CZ_CARDSUP] = flt_card_supply;
        raw_d[CZ_REMOVAL] = ~card_present;
    end

    // Causes only count while a session is open
    always_comb begin
        cause_vec = session_active ? raw_d : '0;
        fire      = |cause_vec;
        // Hardware conditions that forbid opening a session
        hw_block  = |raw_d[CAUSE_W-1:CZ_OCP];
    end

endmodule

// File: rtl/card_deact_timer.sv
module card_deact_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

    AST_TMR_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5

    AST_TMR_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q == '0) |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/card_deact_seq.sv
module card_deact_seq
    import card_deact_pkg::*;
#(
    parameter int CYC_PER_US   = 50,
    parameter int RST_HALVES   = 1,
    parameter int CLK_HALVES   = 15,
    parameter int IO_HALVES    = 1,
    parameter int VCC_HALVES   = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_stop,
    input  logic               flt_overcurrent,
    input  logic               flt_overtemp,
    input  logic               flt_logic_supply,
    input  logic               flt_card_supply,
    input  logic               card_present,
    output logic               card_rst_o,
    output logic               card_clk_en_o,
    output logic               card_io_en_o,
    output logic               card_vcc_en_o,
    output logic               deact_done_o,
    output logic [CAUSE_W-1:0] deact_cause_o
);

    // Cycles in half a microsecond; the step delays are multiples of it
    localparam int HALF     = CYC_PER_US / 2;
    localparam int MAX_A    = (RST_HALVES > CLK_HALVES) ? RST_HALVES : CLK_HALVES;
    localparam int MAX_B    = (IO_HALVES > VCC_HALVES) ? IO_HALVES : VCC_HALVES;
    localparam int LONGEST  = HALF * ((MAX_A > MAX_B) ? MAX_A : MAX_B);
    localparam int CNT_W    = $clog2(LONGEST + 1);

    localparam logic [CNT_W-1:0] LD_RST = CNT_W'(HALF * RST_HALVES - 1);
    localparam logic [CNT_W-1:0] LD_CLK = CNT_W'(HALF * CLK_HALVES - 1);
    localparam logic [CNT_W-1:0] LD_IO  = CNT_W'(HALF * IO_HALVES - 1);
    localparam logic [CNT_W-1:0] LD_VCC = CNT_W'(HALF * VCC_HALVES - 1);

    seq_regs_t          q, n;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_zero;
    logic [CAUSE_W-1:0] cause_vec;
    logic               fire;
    logic               hw_block;
    logic               session_active;

    assign session_active = (q.state == ST_ON);

    card_deact_trigger u_trigger (
        .session_active   (session_active),
        .start_stop       (start_stop),
        .flt_overcurrent  (flt_overcurrent),
        .flt_overtemp     (flt_overtemp),
        .flt_logic_supply (flt_logic_supply),
        .flt_card_supply  (flt_card_supply),
        .card_present     (card_present),
        .cause_vec        (cause_vec),
        .fire             (fire),
        .hw_block         (hw_block)
    );

    card_deact_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_comb begin
        n        = q;
        n.done   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (q.state)
            ST_OFF: begin
                // Edge-qualified activation; refused under any fault
                if (start_stop && !q.ss_prev && !hw_block) begin
                    n.state  = ST_ON;
                    n.rst_hi = 1'b1;
                    n.clk_en = 1'b1;
                    n.io_en  = 1'b1;
                    n.vcc_en = 1'b1;
                    n.cause  = '0;
                end
            end
            ST_ON: begin
                if (fire) begin
                    n.state  = ST_W_RST;
                    n.cause  = cause_vec;
                    tmr_load = 1'b1;
                    tmr_val  = LD_RST;
                end
            end
            ST_W_RST: begin
                if (tmr_zero) begin
                    n.state  = ST_W_CLK;
                    n.rst_hi = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = LD_CLK;
                end
            end
            ST_W_CLK: begin
                if (tmr_zero) begin
                    n.state  = ST_W_IO;
                    n.clk_en = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = LD_IO;
                end
            end
            ST_W_IO: begin
                if (tmr_zero) begin
                    n.state  = ST_W_VCC;
                    n.io_en  = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = LD_VCC;
                end
            end
            ST_W_VCC: begin
                if (tmr_zero) begin
                    n.state  = ST_OFF;
                    n.vcc_en = 1'b0;
                    n.done   = 1'b1;
                end
            end
            default: begin
                n = SEQ_RESET;
            end
        endcase
        n.ss_prev = start_stop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= SEQ_RESET;
        end else begin
            q <= n;
        end
    end

    assign card_rst_o    = q.rst_hi;
    assign card_clk_en_o = q.clk_en;
    assign card_io_en_o  = q.io_en;
    assign card_vcc_en_o = q.vcc_en;
    assign deact_done_o  = q.done;
    assign deact_cause_o = q.cause;

    AST_CLK_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
        $fell(card_clk_en_o) |-> !card_rst_o); // R9

    AST_IO_AFTER_CLK: assert property (@(posedge clk) disable iff (rst)
        $fell(card_io_en_o) |-> !card_clk_en_o); // R9

    AST_VCC_LAST: assert property (@(posedge clk) disable iff (rst)
        $fell(card_vcc_en_o) |-> (!card_io_en_o && deact_done_o)); // R8

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        deact_done_o |=> !deact_done_o); // R8

    AST_CAUSE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        ((q.state != ST_OFF && q.state != ST_ON) &&
         $past(q.state != ST_OFF && q.state != ST_ON)) |-> $stable(deact_cause_o)); // R10

    AST_NO_WAKE_MIDWAY: assert property (@(posedge clk) disable iff (rst)
        (q.state != ST_OFF && q.state != ST_ON) |=> (q.state != ST_ON)); // R11

    AST_CAUSE_NONZERO: assert property (@(posedge clk) disable iff (rst)
        $fell(card_rst_o) |-> (deact_cause_o != '0)); // R4

endmodule

// File: tb/card_deact_seq_bench.sv
module card_deact_seq_bench;

    localparam int CPU = 4;
    localparam int H   = CPU / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ss = 1'b0, ocp = 1'b0, otp = 1'b0, lsf = 1'b0, csf = 1'b0, pres = 1'b1;
    logic       o_rst, o_clk, o_io, o_vcc, o_done;
    logic [5:0] o_cause;

    int checks   = 0;
    int failures = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    card_deact_seq #(.CYC_PER_US(CPU)) u_card_deact_seq (
        .clk(clk), .rst(rst), .start_stop(ss),
        .flt_overcurrent(ocp), .flt_overtemp(otp),
        .flt_logic_supply(lsf), .flt_card_supply(csf),
        .card_present(pres),
        .card_rst_o(o_rst), .card_clk_en_o(o_clk), .card_io_en_o(o_io),
        .card_vcc_en_o(o_vcc), .deact_done_o(o_done), .deact_cause_o(o_cause)
    );

    // Behavioural reference: 0 off, 1 session, 2 shutting down
    int       m_state = 0;
    int       m_t     = 0;
    bit       m_prev  = 1'b0;
    bit       m_done  = 1'b0;
    bit [5:0] m_cause = '0;

    always @(posedge clk) begin
        bit       prev_ss;
        bit [5:0] c;
        prev_ss = m_prev;
        m_prev  = ss;
        m_done  = 1'b0;
        if (rst) begin
            m_state = 0; m_t = 0; m_cause = '0; m_prev = 1'b0;
        end else begin
            case (m_state)
                0: if (ss && !prev_ss && !ocp && !otp && !lsf && !csf && pres) begin
                       m_state = 1; m_cause = '0;
                   end
                1: begin
                       c = {!pres, csf, lsf, otp, ocp, !ss};
                       if (c != 0) begin m_state = 2; m_t = 0; m_cause = c; end
                   end
                default: begin
                       m_t++;
                       if (m_t == 18 * H) begin m_state = 0; m_done = 1'b1; end
                   end
            endcase
        end
    end

    function automatic logic [9:0] expect_vec();
        logic r, k, i, v;
        if (m_state == 0)      begin r = 0; k = 0; i = 0; v = 0; end
        else if (m_state == 1) begin r = 1; k = 1; i = 1; v = 1; end
        else begin
            r = (m_t < H); k = (m_t < 16 * H); i = (m_t < 17 * H); v = 1'b1;
        end
        return {r, k, i, v, m_cause};
    endfunction

    // Cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        logic [10:0] act, exp;
        if (!rst) begin
            act = {o_rst, o_clk, o_io, o_vcc, o_cause, o_done};
            exp = {expect_vec(), m_done};
            checks++;
            if (act !== exp) begin
                failures++;
                $display("FAIL %s cycle compare: actual=%b expected=%b", cur_req, act, exp);
            end
        end
    end

    task automatic tick(input int cnt);
        repeat (cnt) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic activate();
        ss = 1'b0; tick(1);
        ss = 1'b1; tick(2);
        chk("R2 session open", {o_rst, o_clk, o_io, o_vcc}, 4'b1111);
        chk("R13 cause cleared on open", o_cause, 6'd0);
    endtask

    task automatic finish_seq();
        tick(18 * H + 3);
        chk("R8 supply off after sequence", o_vcc, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick(3);
        chk("R1 reset outputs", {o_rst, o_clk, o_io, o_vcc, o_done, o_cause}, 11'd0);
        rst = 1'b0;
        tick(2);
        chk("R1 idle after reset", {o_rst, o_clk, o_io, o_vcc, o_done, o_cause}, 11'd0);

        // Software close with full timing
        cur_req = "R2";
        activate();
        cur_req = "R3/R5/R6/R7/R8";
        ss = 1'b0;
        tick(H + 1);
        chk("R5 reset low", o_rst, 1'b0);
        chk("R5 clock still on", o_clk, 1'b1);
        finish_seq();
        chk("R3 software cause", o_cause, 6'b000001);
        tick(4);
        chk("R13 cause kept while off", o_cause, 6'b000001);

        // Each hardware cause in turn
        for (int k = 0; k < 5; k++) begin
            cur_req = "R4";
            activate();
            case (k)
                0: ocp = 1'b1;
                1: otp = 1'b1;
                2: lsf = 1'b1;
                3: csf = 1'b1;
                default: pres = 1'b0;
            endcase
            tick(1);
            ocp = 1'b0; otp = 1'b0; lsf = 1'b0; csf = 1'b0; pres = 1'b1;
            finish_seq();
            chk("R4 fault cause bit", o_cause, 32'd1 << (k + 1));
        end

        // Software close and a fault in the same cycle
        cur_req = "R4";
        activate();
        ss = 1'b0; ocp = 1'b1;
        tick(1);
        ocp = 1'b0;
        finish_seq();
        chk("R4 simultaneous causes", o_cause, 6'b000011);

        // Further triggers during a shutdown are ignored
        cur_req = "R10";
        activate();
        otp = 1'b1;
        tick(1);
        otp = 1'b0;
        tick(3 * H);
        ss = 1'b0; lsf = 1'b1; pres = 1'b0;
        tick(2);
        ss = 1'b1;
        tick(1);
        ss = 1'b0; lsf = 1'b0; pres = 1'b1;
        chk("R10 cause unchanged", o_cause, 6'b000100);
        chk("R11 no reopen midway", o_rst, 1'b0);
        finish_seq();

        // Activation raised exactly on the supply-off edge, then held high
        cur_req = "R11";
        activate();
        ss = 1'b0;
        tick(18 * H);
        ss = 1'b1;
        tick(6);
        chk("R11 refused at final edge", {o_rst, o_vcc}, 2'b00);
        ss = 1'b0; tick(1);
        ss = 1'b1; tick(2);
        chk("R11 fresh edge opens", o_vcc, 1'b1);
        ss = 1'b0;
        finish_seq();

        // Faults while off, and refused activation
        cur_req = "R12";
        ocp = 1'b1; csf = 1'b1; pres = 1'b0;
        tick(3);
        chk("R12 faults ignored while off", {o_rst, o_clk, o_io, o_vcc, o_done}, 5'd0);
        chk("R13 cause untouched while off", o_cause, 6'b000001);
        ocp = 1'b0; csf = 1'b0;
        ss = 1'b1; tick(3);
        chk("R12 refused with card absent", o_vcc, 1'b0);
        pres = 1'b1; ss = 1'b0; otp = 1'b1; tick(1);
        ss = 1'b1; tick(3);
        chk("R12 refused under fault", o_vcc, 1'b0);
        otp = 1'b0; ss = 1'b0; tick(1);
        ss = 1'b1; tick(2);
        chk("R2 opens once clear", o_vcc, 1'b1);
        ss = 1'b0;
        finish_seq();

        // Reset in the middle of a shutdown
        cur_req = "R1";
        activate();
        ss = 1'b0;
        tick(4 * H);
        rst = 1'b1;
        tick(2);
        chk("R1 reset mid-sequence", {o_rst, o_clk, o_io, o_vcc, o_done, o_cause}, 11'd0);
        rst = 1'b0;
        tick(3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule